// File: doc/BRIEF.md
# Address-Filtering Receive Gate

This block stands between a serial receiver's deframer and its receive buffer. Each deframed word arrives with its ninth bit on a valid/ready stream. The gate decides whether the word goes on to the buffer, and whether it counts as an address or as a character match. A recognised address or match sets a sticky flag and produces a one-cycle interrupt pulse. Software clears the flag with a one-cycle pulse.

Two mode bits pick the recognition rule:

| `mode_addr_en` | `mode_match_sel` | Rule |
|---|---|---|
| 1 | 0 | Any word with the ninth bit high is an address. |
| 0 | 0 | A word is an address when its ninth bit is high; it matches only when it also equals the programmed character. |
| 1 | 1 | Only the first word after a break is an address; it matches when it equals the programmed character. |
| 0 | 1 | Character search: nothing is filtered, and a word equal to the programmed character raises the flag. |

In the three address modes, a matching address opens the gate for the data words that follow it. A non-matching address shuts the gate, and the words after it are dropped until the next address.

Back-pressure: `in_ready` equals `out_ready`. A word is consumed only in a cycle where `in_valid` and `in_ready` are both high. Only a consumed word changes state. `out_valid` may be high while `out_ready` is low; in that case nothing is consumed. A consumed word that the gate drops is absorbed without a write.

Top module: `rx_addr_gate`

## Requirements
- R1: With `mode_addr_en`=1 and `mode_match_sel`=0, a consumed word with `in_bit9`=1 is an address and always matches. It sets `match_flag` on the following cycle.
- R2: With `mode_addr_en`=0 and `mode_match_sel`=1, a consumed word equal to `match_char` sets `match_flag`. Every consumed word is offered on the output while the flag is clear, including the word that sets the flag.
- R3: With both mode bits at 1, only the first consumed word after a `brk_seen` pulse is an address, and it matches only when it equals `match_char`. Other words are data, whatever their value.
- R4: With both mode bits at 0, a consumed word with `in_bit9`=1 is an address. It matches only when it also equals `match_char`. A word with `in_bit9`=0 is data even when it equals `match_char`.
- R5: An address word is never presented on `out_valid`.
- R6: In an address mode, data words after a matching address are written. Data words after a non-matching address are dropped, and a non-matching address leaves `match_flag` unchanged.
- R7: A word that would be written while `match_flag` is high is not written. Instead, `overrun` is high for that cycle.
- R8: After reset, and after any change of the mode bits, the gate is closed. No data word passes in an address mode until a matching address arrives.
- R9: A `flag_clr` pulse clears `match_flag` on the next cycle. A set event in the same cycle takes priority, and the flag stays high.
- R10: `irq` is a one-cycle pulse in the first cycle that `match_flag` is high after a set event.
- R11: `in_ready` follows `out_ready`. A word offered while `out_ready` is low changes neither the flag nor the gate state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_addr_en | input | 1 | Mode bit: address recognition enable |
| mode_match_sel | input | 1 | Mode bit: character-compare selection |
| match_char | input | DW | Programmed address or search character |
| brk_seen | input | 1 | One-cycle strobe: a break was detected |
| flag_clr | input | 1 | One-cycle pulse that clears the flag |
| in_valid | input | 1 | Received word is valid |
| in_ready | output | 1 | Gate can consume the word |
| in_data | input | DW | Received word |
| in_bit9 | input | 1 | Ninth bit of the received word |
| out_valid | output | 1 | Word is offered to the buffer |
| out_ready | input | 1 | Buffer can take a word |
| out_data | output | DW | Word to the buffer |
| match_flag | output | 1 | Sticky address/match flag |
| irq | output | 1 | One-cycle interrupt pulse |
| overrun | output | 1 | A write was refused because the flag was set |

## Verification
The assertions assume that `brk_seen` and `flag_clr` are single-cycle pulses. They also assume that the mode bits and `match_char` are not changed in a cycle that consumes a word, because the gate-closing check covers only mode changes that have no address word beside them. The stimulus changes modes only while `in_valid` is low and waits idle cycles before the next word. It holds `match_char` constant and raises a break strobe only between words.

// File: rtl/rx_gate_pkg.sv
package rx_gate_pkg;
  // Encoding is {mode_addr_en, mode_match_sel}
  typedef enum logic [1:0] {
    GM_BIT9_CHAR = 2'b00,
    GM_CHAR_SRCH = 2'b01,
    GM_BIT9_ONLY = 2'b10,
    GM_BRK_CHAR  = 2'b11
  } gate_mode_e;
endpackage

// File: rtl/rx_word_classify.sv
module rx_word_classify
  import rx_gate_pkg::*;
#(
  parameter int DW = 8
) (
  input  gate_mode_e       mode,
  input  logic [DW-1:0]    data,
  input  logic             bit9,
  input  logic [DW-1:0]    match_char,
  input  logic             after_brk,
  output logic             is_addr,
  output logic             hit,
  output logic             filter_on
);
  logic eq;
  assign eq = (data == match_char);

  always_comb begin
    is_addr   = 1'b0;
    hit       = 1'b0;
    filter_on = 1'b1;
    unique case (mode)
      GM_BIT9_CHAR: begin
        is_addr = bit9;
        hit     = bit9 & eq;
      end
      GM_CHAR_SRCH: begin
        filter_on = 1'b0;
        hit       = eq;
      end
      GM_BIT9_ONLY: begin
        is_addr = bit9;
        hit     = bit9;
      end
      GM_BRK_CHAR: begin
        is_addr = after_brk;
        hit     = after_brk & eq;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rx_pass_track.sv
module rx_pass_track
  import rx_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  gate_mode_e mode,
  input  logic       acc,
  input  logic       is_addr,
  input  logic       hit,
  input  logic       brk_seen,
  output logic       pass_eff,
  output logic       after_brk
);
  gate_mode_e mode_q;
  logic       pass_q;
  logic       armed_q;
  logic       mode_chg;

  assign mode_chg  = (mode != mode_q);
  assign pass_eff  = pass_q & ~mode_chg;
  assign after_brk = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= GM_BIT9_CHAR;
      pass_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode;
      armed_q <= brk_seen | (armed_q & ~acc);
      if (acc && is_addr) pass_q <= hit;
      else if (mode_chg)  pass_q <= 1'b0;
    end
  end

  // R8
  mode_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !(acc && is_addr)) |=> !pass_q);
  // R6
  miss_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_addr && !hit) |=> !pass_q);
  // R3
  brk_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !brk_seen) |=> !after_brk);
endmodule

// File: rtl/rx_flag_ctrl.sv
module rx_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= set_evt;
      if (set_evt)  flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  // R9
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_evt) |=> !flag);
  // R10
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
endmodule

// File: rtl/rx_addr_gate.sv
module rx_addr_gate
  import rx_gate_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_addr_en,
  input  logic          mode_match_sel,
  input  logic [DW-1:0] match_char,
  input  logic          brk_seen,
  input  logic          flag_clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_bit9,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          match_flag,
  output logic          irq,
  output logic          overrun
);
  gate_mode_e mode;
  logic acc, is_addr, hit, filter_on, pass_eff, after_brk, wr_ok;

  assign mode     = gate_mode_e'({mode_addr_en, mode_match_sel});
  assign in_ready = out_ready;
  assign acc      = in_valid & out_ready;

  rx_word_classify #(.DW(DW)) u_cls (
    .mode(mode), .data(in_data), .bit9(in_bit9), .match_char(match_char),
    .after_brk(after_brk), .is_addr(is_addr), .hit(hit), .filter_on(filter_on)
  );

  rx_pass_track u_pass (
    .clk(clk), .rst_n(rst_n), .mode(mode), .acc(acc), .is_addr(is_addr),
    .hit(hit), .brk_seen(brk_seen), .pass_eff(pass_eff), .after_brk(after_brk)
  );

  rx_flag_ctrl u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(acc & hit), .clr(flag_clr),
    .flag(match_flag), .irq(irq)
  );

  assign wr_ok     = ~is_addr & (~filter_on | pass_eff);
  assign out_valid = in_valid & wr_ok & ~match_flag;
  assign overrun   = acc & wr_ok & match_flag;
  assign out_data  = in_data;

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && is_addr) |-> !out_valid);
  // R7
  ovr_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !out_valid);
  // R7
  flag_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !match_flag);
  // R11
  stall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !match_flag) |=> !match_flag);
endmodule

// File: tb/test_rx_addr_gate.sv
module test_rx_addr_gate;
  localparam int DW = 8;
  logic clk = 0, rst_n = 0;
  logic mode_addr_en = 0, mode_match_sel = 0, brk_seen = 0, flag_clr = 0;
  logic [DW-1:0] match_char = 8'h5A, in_data = '0;
  logic in_valid = 0, in_bit9 = 0, out_ready = 1;
  logic in_ready, out_valid, match_flag, irq, overrun;
  logic [DW-1:0] out_data;
  int runs = 0, fails = 0;
  bit done = 0;
  logic [DW+1:0] expq[$];

  always #4 clk = ~clk;

  rx_addr_gate #(.DW(DW)) i_rx_addr_gate (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expectation for every consumed word
  always @(negedge clk) begin
    if (in_valid && in_ready && expq.size() > 0) begin
      logic [DW+1:0] e;
      e = expq.pop_front();
      chk(out_valid == e[DW+1], "word write", int'(out_valid), int'(e[DW+1]));
      chk(overrun == e[DW], "word overrun", int'(overrun), int'(e[DW]));
      if (e[DW+1]) chk(out_data == e[DW-1:0], "word data", out_data, e[DW-1:0]);
    end
  end

  task automatic word(input logic [DW-1:0] d, input logic b9, input bit wr, input bit ovr);
    expq.push_back({wr, ovr, d});
    in_data = d; in_bit9 = b9; in_valid = 1;
    @(posedge clk); #1;
    in_valid = 0; flag_clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic clr_pulse();
    flag_clr = 1; @(posedge clk); #1; flag_clr = 0;
  endtask

  task automatic brk_pulse();
    brk_seen = 1; @(posedge clk); #1; brk_seen = 0;
  endtask

  task automatic set_mode(input logic en, input logic sel);
    mode_addr_en = en; mode_match_sel = sel; idle(2);
  endtask

  task automatic flag_is(input bit v, input string tag);
    @(negedge clk);
    chk(match_flag == v, tag, int'(match_flag), int'(v));
    @(posedge clk); #1;
  endtask

  initial begin
    #20; rst_n = 1; @(posedge clk); #1;
    @(negedge clk);
    chk(match_flag == 0 && irq == 0 && out_valid == 0 && overrun == 0, "R8 reset state", int'(match_flag), 0);
    @(posedge clk); #1;

    // R1: ninth-bit address mode
    set_mode(1, 0);
    word(8'h11, 0, 0, 0);                 // R8 closed after reset/mode change
    word(8'h33, 1, 0, 0);                 // R1 address, R5 not written
    @(negedge clk);
    chk(match_flag == 1, "R1 flag set", int'(match_flag), 1);
    chk(irq == 1, "R10 irq pulse", int'(irq), 1);
    @(posedge clk); #1;
    @(negedge clk);
    chk(irq == 0, "R10 irq one cycle", int'(irq), 0);
    @(posedge clk); #1;
    word(8'h44, 0, 0, 1);                 // R7 overrun
    clr_pulse();
    flag_is(0, "R9 clear");
    word(8'h45, 0, 1, 0);                 // R6 passes
    word(8'h46, 0, 1, 0);

    // R4: ninth bit plus character
    set_mode(0, 0);
    word(8'h12, 0, 0, 0);                 // R8 closed after mode change
    word(8'h5A, 0, 0, 0);                 // R4 data, not address
    flag_is(0, "R4 bit9 low no match");
    word(8'h33, 1, 0, 0);                 // R6 non-matching address
    flag_is(0, "R6 miss no flag");
    word(8'h47, 0, 0, 0);                 // R6 dropped
    word(8'h5A, 1, 0, 0);                 // R4 match
    flag_is(1, "R4 match flag");
    clr_pulse();
    word(8'h48, 0, 1, 0);                 // R6 written
    word(8'h5A, 1, 0, 0);
    flag_clr = 1;
    word(8'h5A, 1, 0, 0);                 // R9 set wins over clear
    flag_is(1, "R9 set wins");
    clr_pulse();

    // R3: break-qualified match
    set_mode(1, 1);
    word(8'h5A, 0, 0, 0);                 // R3 no break: data, gate closed
    flag_is(0, "R3 no break no flag");
    brk_pulse();
    word(8'h77, 0, 0, 0);                 // R3 non-matching address
    word(8'h50, 0, 0, 0);                 // R6 dropped
    flag_is(0, "R3 miss after break");
    brk_pulse();
    word(8'h5A, 0, 0, 0);                 // R3 match
    flag_is(1, "R3 match after break");
    clr_pulse();
    word(8'h51, 0, 1, 0);
    word(8'h5A, 0, 1, 0);                 // R3 later equal word is data

    // R2: character search
    set_mode(0, 1);
    word(8'h10, 0, 1, 0);
    word(8'h5A, 0, 1, 0);                 // R2 written and flagged
    flag_is(1, "R2 search flag");
    word(8'h20, 0, 0, 1);                 // R7 overrun
    clr_pulse();
    word(8'h21, 1, 1, 0);                 // R2 unfiltered

    // R11: back-pressure
    out_ready = 0; in_data = 8'h5A; in_valid = 1;
    @(negedge clk);
    chk(in_ready == 0, "R11 ready follows", int'(in_ready), 0);
    @(posedge clk); #1;
    in_valid = 0; out_ready = 1;
    flag_is(0, "R11 stalled word ignored");

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule